// File: doc/BRIEF.md
# Dual-Class Credit-Gated Packet Launch Arbiter

This block decides which packet goes out next on a high-speed serial link. Three queues offer packets: transaction packets, periodic data packets and asynchronous data packets. The first two draw on a shared Type1 pool of link credits. Asynchronous data draws on a separate Type2 pool. A queue takes part in arbitration only while its pool holds at least one credit. The winner is picked by a fixed class order, and its grant stays in place until the packet's last cycle.

Each pool counts the credits the link partner still has free. It also checks that credit-return commands arrive in index order. Each pool runs a timer that measures how long the oldest outstanding credit has waited. When that timer reaches a parameterised limit, a timeout flag for the pool goes high. A packet that has been granted always runs to its end. The only thing that cuts it short is the synchronous reset, which stands for warm reset or recovery.

Top module: `dual_class_launch_arb`

## Requirements
- R1: With the arbiter idle, a ready transaction queue (bit 0 of the ready and grant vectors) whose Type1 pool holds a credit is granted on the next clock edge, ahead of either data queue.
- R2: With the arbiter idle and no eligible transaction packet, a ready periodic data queue (bit 1) is granted ahead of the asynchronous data queue (bit 2).
- R3: Each pool starts with CREDITS credits. A grant to bit 0 or bit 1 takes one Type1 credit. A grant to bit 2 takes one Type2 credit. A queue whose pool is empty is never granted.
- R4: A higher-priority queue that has no credit does not block an eligible lower-priority queue.
- R5: At most one grant is high at a time. A grant stays unchanged until the clock edge on which end_of_pkt is high, and it drops on that edge. A new choice is made only while no grant is high.
- R6: A credit-return command is a 3-bit field. Bit 2 selects the series: 0 means Type1, 1 means Type2. Bits 1:0 carry the credit index. A return is accepted, and its pool gains one credit, only if its index equals the next expected index for that series. Expected indices start at 0 and count up modulo CREDITS.
- R7: A return with the wrong index, or a return to a pool that is already full, leaves the credit count unchanged. It sets that series' bit in credit_err: bit 0 for Type1, bit 1 for Type2. The bit then stays set until reset.
- R8: A pool's timer counts every cycle while credits are outstanding. It restarts on each accepted return and is cleared when the pool is full. credit_timeout for that series goes high TIMEOUT_CYCLES edges after the consuming edge when no return is accepted in between.
- R9: While rst_n is low, all grants drop, both pools return to full credit, the expected indices go back to 0, and the timers and error flags are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (also warm reset / recovery) |
| queue_ready | input | 3 | Packet ready: bit 0 transaction, bit 1 periodic data, bit 2 asynchronous data |
| end_of_pkt | input | 1 | Last cycle of the granted packet |
| ret_valid | input | 1 | Credit-return command strobe |
| ret_cmd | input | 3 | Bit 2 series, bits 1:0 credit index |
| queue_grant | output | 3 | One-hot grant, same bit order as queue_ready |
| credit_timeout | output | 2 | Timer reached limit: bit 0 Type1, bit 1 Type2 |
| credit_err | output | 2 | Sticky out-of-order return flag: bit 0 Type1, bit 1 Type2 |

## Verification
A credit count that has drifted shows up at the ports as a grant that goes missing, or as one that appears when it should not. Which one appears depends on how many launches have happened since the last full pool. For that reason the bench predicts every arbitration result from its own credit model, and compares it on the first falling edge after the deciding clock edge. A wrong expected index shows on credit_err one edge after the return that exposes it. A timer fault shows as credit_timeout rising one edge early or late, so that window is checked cycle by cycle. A stuck grant shows as a grant that does not drop on the edge where end_of_pkt is high.

// File: rtl/dca_pkg.sv
package dca_pkg;
    // Queue positions in the ready and grant vectors
    localparam int Q_TXN = 0;
    localparam int Q_PER = 1;
    localparam int Q_ASY = 2;
    localparam int NUM_Q = 3;
    // Credit series indices
    localparam int SER_T1 = 0;
    localparam int SER_T2 = 1;
    localparam int NUM_SER = 2;
    // Bit of the return command that selects the series
    localparam int RET_SER_BIT = 2;
endpackage

// File: rtl/dca_credit_pool.sv
// Credit pool for one traffic class.
// Tracks the remote credits, checks the in-order return index, and times
// outstanding credits. Assumes consume is asserted only while avail is high.
module dca_credit_pool #(
    parameter int CREDITS        = 4,
    parameter int TIMEOUT_CYCLES = 255,
    localparam int IDX_W = (CREDITS > 1) ? $clog2(CREDITS) : 1,
    localparam int CNT_W = $clog2(CREDITS + 1),
    localparam int TMR_W = $clog2(TIMEOUT_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             consume,
    input  logic             ret_valid,
    input  logic [IDX_W-1:0] ret_idx,
    output logic             avail,
    output logic [CNT_W-1:0] count,
    output logic             timeout,
    output logic             proto_err
);
    localparam logic [CNT_W-1:0] FULL  = CNT_W'(CREDITS);
    localparam logic [TMR_W-1:0] LIMIT = TMR_W'(TIMEOUT_CYCLES);
    localparam logic [IDX_W-1:0] LAST  = IDX_W'(CREDITS - 1);

    logic [IDX_W-1:0] exp_idx;
    logic [TMR_W-1:0] timer;
    logic             ret_ok;

    assign ret_ok  = ret_valid && (ret_idx == exp_idx) && (count != FULL);
    assign avail   = (count != '0);
    assign timeout = (timer == LIMIT);

    // Credit count: add an accepted return, subtract a launch
    always_ff @(posedge clk) begin
        if (!rst_n)                 count <= FULL;
        else if (ret_ok && !consume) count <= count + 1'b1;
        else if (!ret_ok && consume) count <= count - 1'b1;
    end

    // Next expected return index, wrapping at CREDITS
    always_ff @(posedge clk) begin
        if (!rst_n)      exp_idx <= '0;
        else if (ret_ok) exp_idx <= (exp_idx == LAST) ? '0 : exp_idx + 1'b1;
    end

    // Sticky flag for rejected returns
    always_ff @(posedge clk) begin
        if (!rst_n)                    proto_err <= 1'b0;
        else if (ret_valid && !ret_ok) proto_err <= 1'b1;
    end

    // Timer for outstanding credits, saturating at the limit
    always_ff @(posedge clk) begin
        if (!rst_n)                 timer <= '0;
        else if (ret_ok)            timer <= '0;
        else if (count == FULL)     timer <= '0;
        else if (timer != LIMIT)    timer <= timer + 1'b1;
    end
endmodule

// File: rtl/dca_prio_pick.sv
// Fixed-priority selection among the queues that have credit.
// Order: transaction, then periodic data, then asynchronous data.
// Purely combinational; the caller samples it only when idle.
module dca_prio_pick
    import dca_pkg::*;
(
    input  logic [NUM_Q-1:0]   ready,
    input  logic [NUM_SER-1:0] avail,
    output logic [NUM_Q-1:0]   pick
);
    logic [NUM_Q-1:0] eligible;

    // Mask each queue with its own class's credit availability
    always_comb begin
        eligible        = '0;
        eligible[Q_TXN] = ready[Q_TXN] & avail[SER_T1];
        eligible[Q_PER] = ready[Q_PER] & avail[SER_T1];
        eligible[Q_ASY] = ready[Q_ASY] & avail[SER_T2];
    end

    // Keep only the highest-priority eligible queue
    always_comb begin
        pick = '0;
        if (eligible[Q_TXN])      pick[Q_TXN] = 1'b1;
        else if (eligible[Q_PER]) pick[Q_PER] = 1'b1;
        else if (eligible[Q_ASY]) pick[Q_ASY] = 1'b1;
    end
endmodule

// File: rtl/dual_class_launch_arb.sv
// Launch arbiter with two credit classes.
// Grants one queue at a time and holds the grant until end_of_pkt.
// Charges the credit on the granting edge and routes credit returns by
// ret_cmd bit 2. Assumes end_of_pkt is sampled only while a grant is high.
module dual_class_launch_arb
    import dca_pkg::*;
#(
    parameter int CREDITS        = 4,
    parameter int TIMEOUT_CYCLES = 255,
    localparam int IDX_W = (CREDITS > 1) ? $clog2(CREDITS) : 1,
    localparam int CNT_W = $clog2(CREDITS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_Q-1:0]   queue_ready,
    input  logic               end_of_pkt,
    input  logic               ret_valid,
    input  logic [IDX_W:0]     ret_cmd,
    output logic [NUM_Q-1:0]   queue_grant,
    output logic [NUM_SER-1:0] credit_timeout,
    output logic [NUM_SER-1:0] credit_err
);
    logic [NUM_Q-1:0]   pick;
    logic [NUM_SER-1:0] avail;
    logic [NUM_SER-1:0] consume;
    logic [CNT_W-1:0]   pool_cnt [NUM_SER];
    logic               busy;

    assign busy = |queue_grant;

    // Credit charge per class on the granting edge
    assign consume[SER_T1] = !busy && (pick[Q_TXN] || pick[Q_PER]);
    assign consume[SER_T2] = !busy && pick[Q_ASY];

    dca_prio_pick u_pick (
        .ready (queue_ready),
        .avail (avail),
        .pick  (pick)
    );

    // One pool per credit series
    for (genvar s = 0; s < NUM_SER; s++) begin : g_pool
        dca_credit_pool #(
            .CREDITS        (CREDITS),
            .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
        ) u_pool (
            .clk       (clk),
            .rst_n     (rst_n),
            .consume   (consume[s]),
            .ret_valid (ret_valid && (ret_cmd[IDX_W] == 1'(s))),
            .ret_idx   (ret_cmd[IDX_W-1:0]),
            .avail     (avail[s]),
            .count     (pool_cnt[s]),
            .timeout   (credit_timeout[s]),
            .proto_err (credit_err[s])
        );
    end

    // Grant register: choose when idle, release on end of packet
    always_ff @(posedge clk) begin
        if (!rst_n)                  queue_grant <= '0;
        else if (busy && end_of_pkt) queue_grant <= '0;
        else if (!busy)              queue_grant <= pick;
    end
endmodule

// File: rtl/dca_checker.sv
// Protocol checker for dual_class_launch_arb; attached with bind below.
module dca_checker #(
    parameter int CREDITS = 4,
    localparam int CNT_W = $clog2(CREDITS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       ready,
    input logic [2:0]       grant,
    input logic             eop,
    input logic [1:0]       avail,
    input logic [CNT_W-1:0] cnt_t1,
    input logic [CNT_W-1:0] cnt_t2,
    input logic [1:0]       tmo,
    input logic [1:0]       err
);
    assert_txn_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == 3'b000 && ready[0] && avail[0]) |=> grant == 3'b001);

    assert_per_before_asy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == 3'b000 && !ready[0] && ready[1] && avail[0]) |=> grant == 3'b010);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_t1 <= CNT_W'(CREDITS)) && (cnt_t2 <= CNT_W'(CREDITS)));

    assert_no_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == 3'b000 && ready[2] && avail[1] && !((ready[0] || ready[1]) && avail[0]))
        |=> grant == 3'b100);

    assert_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != 3'b000 && !eop) |=> $stable(grant));

    assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != 3'b000 && eop) |=> grant == 3'b000);

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (err != 2'b00) |=> ((err & $past(err)) == $past(err)));

    assert_tmo_outstanding_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmo[0] || cnt_t1 < CNT_W'(CREDITS)) && (!tmo[1] || cnt_t2 < CNT_W'(CREDITS)));
endmodule

bind dual_class_launch_arb dca_checker #(.CREDITS(CREDITS)) u_dca_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .ready  (queue_ready),
    .grant  (queue_grant),
    .eop    (end_of_pkt),
    .avail  (avail),
    .cnt_t1 (pool_cnt[0]),
    .cnt_t2 (pool_cnt[1]),
    .tmo    (credit_timeout),
    .err    (credit_err)
);

// File: tb/dual_class_launch_arb_bench.sv
module dual_class_launch_arb_bench;
    localparam int CR  = 4;
    localparam int LIM = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] queue_ready = '0;
    logic       end_of_pkt = 1'b0;
    logic       ret_valid = 1'b0;
    logic [2:0] ret_cmd = '0;
    logic [2:0] queue_grant;
    logic [1:0] credit_timeout;
    logic [1:0] credit_err;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    // Reference model state
    int m_cnt [2];
    int m_exp [2];
    bit m_err [2];

    always #2.5 clk = ~clk;

    dual_class_launch_arb #(.CREDITS(CR), .TIMEOUT_CYCLES(LIM)) u_dual_class_launch_arb (
        .clk(clk), .rst_n(rst_n), .queue_ready(queue_ready), .end_of_pkt(end_of_pkt),
        .ret_valid(ret_valid), .ret_cmd(ret_cmd), .queue_grant(queue_grant),
        .credit_timeout(credit_timeout), .credit_err(credit_err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] model_pick(input logic [2:0] rdy);
        logic [2:0] e;
        e = rdy & {m_cnt[1] > 0, m_cnt[0] > 0, m_cnt[0] > 0};
        if (e[0]) return 3'b001;
        if (e[1]) return 3'b010;
        if (e[2]) return 3'b100;
        return 3'b000;
    endfunction

    task automatic model_reset();
        for (int s = 0; s < 2; s++) begin
            m_cnt[s] = CR; m_exp[s] = 0; m_err[s] = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; queue_ready = '0; end_of_pkt = 1'b0; ret_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    // Offer queues, check the choice, then run the packet to its end
    task automatic do_launch(input logic [2:0] rdy, input int hold, input string tag);
        logic [2:0] exp;
        exp = model_pick(rdy);
        queue_ready = rdy;
        @(negedge clk);
        check(queue_grant == exp, tag, queue_grant, exp);
        if (exp != 3'b000) begin
            if (exp[2]) m_cnt[1]--; else m_cnt[0]--;
            for (int h = 0; h < hold; h++) begin
                @(negedge clk);
                check(queue_grant == exp, "R5 hold", queue_grant, exp);
            end
            end_of_pkt = 1'b1;
            @(negedge clk);
            end_of_pkt = 1'b0;
            queue_ready = '0;
            check(queue_grant == 3'b000, "R5 release", queue_grant, 0);
        end else begin
            queue_ready = '0;
        end
    endtask

    // Send one credit-return command and compare the error flags
    task automatic do_return(input bit ser, input logic [1:0] idx);
        ret_valid = 1'b1;
        ret_cmd = {ser, idx};
        @(negedge clk);
        ret_valid = 1'b0;
        if (int'(idx) == m_exp[ser] && m_cnt[ser] < CR) begin
            m_cnt[ser]++; m_exp[ser] = (m_exp[ser] + 1) % CR;
        end else begin
            m_err[ser] = 1'b1;
        end
        check(credit_err == {m_err[1], m_err[0]}, "R6 R7 err flags", credit_err, {m_err[1], m_err[0]});
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            failures++;
            $display("FAIL R5 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        model_reset();
        do_reset();
        @(negedge clk);
        // R9 reset state
        check(queue_grant == 3'b000, "R9 grant after reset", queue_grant, 0);
        check(credit_err == 2'b00, "R9 err after reset", credit_err, 0);
        check(credit_timeout == 2'b00, "R9 timeout after reset", credit_timeout, 0);

        // R8 timer window on Type1
        queue_ready = 3'b001;
        @(negedge clk);
        check(queue_grant == 3'b001, "R8 R1 launch", queue_grant, 1);
        m_cnt[0]--;
        queue_ready = '0; end_of_pkt = 1'b1;
        @(negedge clk);
        end_of_pkt = 1'b0;
        repeat (LIM - 2) @(negedge clk);
        check(credit_timeout == 2'b00, "R8 before limit", credit_timeout, 0);
        @(negedge clk);
        check(credit_timeout == 2'b01, "R8 at limit", credit_timeout, 1);
        do_return(1'b0, 2'd0);
        check(credit_timeout == 2'b00, "R8 restart on return", credit_timeout, 0);

        // R1, R2 directed priority
        do_launch(3'b111, 1, "R1 txn beats data");
        do_launch(3'b110, 0, "R2 periodic beats async");
        do_launch(3'b100, 2, "R3 async alone");

        // R3, R4: drain Type1 and check async still goes
        do_launch(3'b001, 0, "R3 drain t1");
        do_launch(3'b010, 0, "R3 drain t1");
        check(m_cnt[0] == 0, "R3 bench model drained", m_cnt[0], 0);
        do_launch(3'b011, 0, "R3 no grant without credit");
        do_launch(3'b111, 1, "R4 async not blocked");

        // R6 in-order returns including series bit
        do_return(1'b0, 2'd1);
        do_launch(3'b001, 0, "R6 t1 credit back");
        do_return(1'b1, 2'd0);

        // R7 wrong index and return to a full pool
        do_return(1'b1, 2'd3);
        do_launch(3'b100, 0, "R7 t2 count unchanged");
        do_reset();
        do_return(1'b0, 2'd0);

        // R9 reset restores full credit
        do_reset();
        for (int k = 0; k < CR; k++) do_launch(3'b010, 0, "R9 full pool after reset");
        do_launch(3'b011, 0, "R9 pool empty after four");
        do_reset();

        // Constrained random mix
        void'($urandom(32'h5eed_0a11));
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(0, 99) < 55) begin
                do_launch(3'($urandom_range(0, 7)), $urandom_range(0, 2), "R1 R2 R4 random launch");
            end else begin
                bit s;
                logic [1:0] ix;
                s = 1'($urandom_range(0, 1));
                ix = ($urandom_range(0, 99) < 90) ? 2'(m_exp[s]) : 2'($urandom_range(0, 3));
                do_return(s, ix);
            end
            if ($urandom_range(0, 299) == 0) do_reset();
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule